// File: doc/BRIEF.md
# Accelerator Instruction Sequencer

This block sits between the instruction buffer of a matrix-inference accelerator and its datapath. It takes one wide, fixed-format instruction at a time. It splits the instruction into its address, length, flag and opcode fields. It then expands that single instruction into a stream of row-level micro-operations. Each micro-operation carries an input-buffer read address, an accumulator (output) write address, the instruction's flags and a kind code. One instruction therefore keeps the datapath busy for many cycles while the instruction buffer stays idle.

Row-type instructions cover the two host transfers, the matrix multiply/convolve and the activation. Each issues one micro-op per row, and both addresses step by one per row until the length is used up. The read-weights instruction issues a single micro-op carrying the weight address and retires at once, so that the weight fetch overlaps with the multiplies that follow it. A repeat prefix makes the next instruction run again, from its original addresses, without being fetched again. Every accepted instruction ends with a one-cycle retire pulse. An unrecognised opcode raises an error pulse and is retired without producing any work.

Top module: `accel_instr_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `uop_valid`, `retire` and `err` are 0 and `ibuf_ready` is 1.
- R2: The instruction word is laid out as follows: bits [23:0] hold the input address, [39:24] the output address, [71:40] the length, [87:72] the flags and [95:88] the opcode. `uop_flags` carries the flags of the running instruction on every micro-op.
- R3: A row instruction with length N > 0 issues exactly N micro-ops per pass. Row k carries input address base_in+k and output address base_out+k, with each address wrapping at its own width. `uop_last` is 1 on row N-1 of each pass and 0 on every other row.
- R4: While `uop_valid` is 1 and `uop_ready` is 0, the micro-op outputs hold their values. The sequencer advances only on a cycle where both are 1.
- R5: `ibuf_ready` is 0 while micro-ops are pending. `retire` is a one-cycle pulse in the cycle after the final micro-op handshake, and in that cycle `retire_kind` shows the kind of the retiring instruction and `ibuf_ready` is 1 again.
- R6: Read-weights (opcode 0x20) issues exactly one micro-op per pass, whatever its length field holds. That micro-op carries the input-address field and has `uop_last` = 1, and the instruction retires right after it is accepted.
- R7: A row instruction whose length field is 0 issues no micro-op and retires in the cycle after it is accepted.
- R8: The repeat prefix (opcode 0xF0, with count C in the length field) issues nothing and does not retire. The next instruction runs C+1 passes, each pass restarting from its original addresses, and retires once at the end of the last pass.
- R9: Any opcode other than 0x11, 0x12, 0x20, 0x30, 0x40 and 0xF0 produces `err` = 1 and `retire` = 1 with `retire_kind` = 0 in the cycle after acceptance. It issues no micro-op and discards any pending repeat count.
- R10: Opcodes map to kind codes on `uop_kind` and `retire_kind` as follows: 0x11 host-to-buffer is 1, 0x12 buffer-to-host is 2, 0x20 read-weights is 3, 0x30 matrix multiply/convolve is 4, and 0x40 activate is 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ibuf_valid | input | 1 | Instruction buffer offers a word |
| ibuf_data | input | 96 | Instruction word |
| ibuf_ready | output | 1 | Sequencer accepts the offered word this cycle |
| uop_valid | output | 1 | Micro-op presented to the datapath |
| uop_ready | input | 1 | Datapath takes the micro-op; low means stall |
| uop_kind | output | 3 | Kind code of the micro-op |
| uop_in_addr | output | 24 | Input-buffer read address |
| uop_out_addr | output | 16 | Accumulator write address |
| uop_flags | output | 16 | Flags of the running instruction |
| uop_last | output | 1 | Final row of the current pass |
| retire | output | 1 | One-cycle instruction completion pulse |
| retire_kind | output | 3 | Kind code of the retiring instruction, 0 for an illegal opcode |
| err | output | 1 | One-cycle illegal-opcode pulse |

## Verification
The assertions assume that the datapath may hold `uop_ready` low for any number of cycles. They also assume that the instruction buffer keeps its word steady until `ibuf_ready` takes it. The stepping check further assumes that the addresses only advance across a handshake that is not the last row of a pass. The bench drives words only through a wait on `ibuf_ready`, and it drops `ibuf_valid` right after the accepting edge. It alternates between an always-ready datapath and a datapath that stalls one cycle in three, so that the hold and stepping properties are exercised with and without back-pressure, including address wrap at the top of both address ranges.

// File: rtl/seq_pkg.sv
// Shared types and opcode constants for the instruction sequencer.
// Assumes an 8-bit opcode field at the top of every instruction word.
package seq_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_HOST_IN  = 8'h11;
    localparam logic [OPC_W-1:0] OPC_HOST_OUT = 8'h12;
    localparam logic [OPC_W-1:0] OPC_WEIGHTS  = 8'h20;
    localparam logic [OPC_W-1:0] OPC_MATMUL   = 8'h30;
    localparam logic [OPC_W-1:0] OPC_ACTIVATE = 8'h40;
    localparam logic [OPC_W-1:0] OPC_REPEAT   = 8'hF0;

    typedef enum logic [2:0] {
        KIND_NONE     = 3'd0,
        KIND_HOST_IN  = 3'd1,
        KIND_HOST_OUT = 3'd2,
        KIND_WEIGHTS  = 3'd3,
        KIND_MATMUL   = 3'd4,
        KIND_ACTIVATE = 3'd5
    } uop_kind_t;

    typedef enum logic [1:0] {
        CLS_ROWS    = 2'd0,
        CLS_SINGLE  = 2'd1,
        CLS_PREFIX  = 2'd2,
        CLS_ILLEGAL = 2'd3
    } instr_class_t;

    // Maps an opcode byte to the micro-op kind it produces.
    function automatic uop_kind_t opcode_kind(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_HOST_IN:  return KIND_HOST_IN;
            OPC_HOST_OUT: return KIND_HOST_OUT;
            OPC_WEIGHTS:  return KIND_WEIGHTS;
            OPC_MATMUL:   return KIND_MATMUL;
            OPC_ACTIVATE: return KIND_ACTIVATE;
            default:      return KIND_NONE;
        endcase
    endfunction

    // Sorts an opcode byte into its execution class.
    function automatic instr_class_t opcode_class(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_HOST_IN, OPC_HOST_OUT, OPC_MATMUL, OPC_ACTIVATE: return CLS_ROWS;
            OPC_WEIGHTS: return CLS_SINGLE;
            OPC_REPEAT:  return CLS_PREFIX;
            default:     return CLS_ILLEGAL;
        endcase
    endfunction

endpackage

// File: rtl/seq_decode.sv
// Field extraction and classification of one instruction word.
// Purely combinational. It assumes the fields are packed from bit 0
// upward: input address, output address, length, flags, opcode.
module seq_decode
    import seq_pkg::*;
#(
    parameter int IN_AW  = 24,
    parameter int OUT_AW = 16,
    parameter int LEN_W  = 32,
    parameter int FLAG_W = 16,
    localparam int INSTR_W = IN_AW + OUT_AW + LEN_W + FLAG_W + OPC_W
) (
    input  logic [INSTR_W-1:0] instr,
    output logic [IN_AW-1:0]   in_addr,
    output logic [OUT_AW-1:0]  out_addr,
    output logic [LEN_W-1:0]   length,
    output logic [FLAG_W-1:0]  flags,
    output uop_kind_t          kind,
    output instr_class_t       cls,
    output logic               zero_len
);
    localparam int OUT_LSB = IN_AW;
    localparam int LEN_LSB = OUT_LSB + OUT_AW;
    localparam int FLG_LSB = LEN_LSB + LEN_W;
    localparam int OPC_LSB = FLG_LSB + FLAG_W;

    logic [OPC_W-1:0] opc;

    // Slice the word into its fields and classify the opcode.
    always_comb begin
        in_addr  = instr[IN_AW-1:0];
        out_addr = instr[OUT_LSB +: OUT_AW];
        length   = instr[LEN_LSB +: LEN_W];
        flags    = instr[FLG_LSB +: FLAG_W];
        opc      = instr[OPC_LSB +: OPC_W];
        kind     = opcode_kind(opc);
        cls      = opcode_class(opc);
        zero_len = (length == '0);
    end
endmodule

// File: rtl/seq_repeat.sv
// Holds the pass count armed by a repeat prefix until the next
// instruction takes it. A later prefix overwrites an earlier one.
module seq_repeat #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [LEN_W-1:0] arm_count,
    input  logic             take,
    output logic [LEN_W-1:0] extra_passes
);
    // Load on a prefix, clear when any other instruction consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            extra_passes <= '0;
        end else if (arm) begin
            extra_passes <= arm_count;
        end else if (take) begin
            extra_passes <= '0;
        end
    end
endmodule

// File: rtl/seq_loop.sv
// Micro-op loop: steps the input and output addresses and counts the
// remaining rows down, restarting the pass while repeats remain.
// Assumes start is only raised while not running.
module seq_loop
    import seq_pkg::*;
#(
    parameter int IN_AW  = 24,
    parameter int OUT_AW = 16,
    parameter int LEN_W  = 32,
    parameter int FLAG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  uop_kind_t         start_kind,
    input  logic              start_single,
    input  logic [IN_AW-1:0]  in_base,
    input  logic [OUT_AW-1:0] out_base,
    input  logic [LEN_W-1:0]  length,
    input  logic [FLAG_W-1:0] flags,
    input  logic [LEN_W-1:0]  passes,
    input  logic              uop_ready,
    output logic              busy,
    output uop_kind_t         kind,
    output logic [IN_AW-1:0]  in_ptr,
    output logic [OUT_AW-1:0] out_ptr,
    output logic [FLAG_W-1:0] flags_q,
    output logic              pass_last,
    output logic              done
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [IN_AW-1:0]  in_base_q;
    logic [OUT_AW-1:0] out_base_q;
    logic [LEN_W-1:0]  pass_len;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  passes_q;
    logic              step;

    // Handshake and end-of-pass decode.
    always_comb begin
        step      = busy && uop_ready;
        pass_last = (remain == ONE);
        done      = step && pass_last && (passes_q == '0);
    end

    // Load on start, then step one row per accepted micro-op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            kind       <= KIND_NONE;
            in_base_q  <= '0;
            out_base_q <= '0;
            in_ptr     <= '0;
            out_ptr    <= '0;
            flags_q    <= '0;
            pass_len   <= '0;
            remain     <= '0;
            passes_q   <= '0;
        end else if (start) begin
            busy       <= 1'b1;
            kind       <= start_kind;
            in_base_q  <= in_base;
            out_base_q <= out_base;
            in_ptr     <= in_base;
            out_ptr    <= out_base;
            flags_q    <= flags;
            pass_len   <= start_single ? ONE : length;
            remain     <= start_single ? ONE : length;
            passes_q   <= passes;
        end else if (step) begin
            if (pass_last) begin
                if (passes_q != '0) begin
                    passes_q <= passes_q - ONE;
                    in_ptr   <= in_base_q;
                    out_ptr  <= out_base_q;
                    remain   <= pass_len;
                end else begin
                    busy <= 1'b0;
                end
            end else begin
                in_ptr  <= in_ptr + 1'b1;
                out_ptr <= out_ptr + 1'b1;
                remain  <= remain - ONE;
            end
        end
    end
endmodule

// File: rtl/accel_instr_seq.sv
// Top of the instruction sequencer. It fetches one word whenever the
// loop is idle, decodes it, and either arms a repeat, starts the loop,
// or retires at once (zero length or illegal opcode). The retire and
// error outputs are registered pulses.
module accel_instr_seq
    import seq_pkg::*;
#(
    parameter int IN_AW  = 24,
    parameter int OUT_AW = 16,
    parameter int LEN_W  = 32,
    parameter int FLAG_W = 16,
    localparam int INSTR_W = IN_AW + OUT_AW + LEN_W + FLAG_W + OPC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ibuf_valid,
    input  logic [INSTR_W-1:0] ibuf_data,
    output logic               ibuf_ready,
    output logic               uop_valid,
    input  logic               uop_ready,
    output logic [2:0]         uop_kind,
    output logic [IN_AW-1:0]   uop_in_addr,
    output logic [OUT_AW-1:0]  uop_out_addr,
    output logic [FLAG_W-1:0]  uop_flags,
    output logic               uop_last,
    output logic               retire,
    output logic [2:0]         retire_kind,
    output logic               err
);
    logic [IN_AW-1:0]  d_in;
    logic [OUT_AW-1:0] d_out;
    logic [LEN_W-1:0]  d_len;
    logic [FLAG_W-1:0] d_flags;
    uop_kind_t         d_kind;
    instr_class_t      d_cls;
    logic              d_zero;

    logic              accept;
    logic              start_run;
    logic              arm_rep;
    logic              take_rep;
    logic              quick_retire;
    logic              illegal;
    logic [LEN_W-1:0]  extra_passes;

    logic              busy;
    uop_kind_t         loop_kind;
    logic              loop_done;

    logic              retire_q;
    uop_kind_t         retire_kind_q;
    logic              err_q;

    seq_decode #(
        .IN_AW(IN_AW), .OUT_AW(OUT_AW), .LEN_W(LEN_W), .FLAG_W(FLAG_W)
    ) u_decode (
        .instr    (ibuf_data),
        .in_addr  (d_in),
        .out_addr (d_out),
        .length   (d_len),
        .flags    (d_flags),
        .kind     (d_kind),
        .cls      (d_cls),
        .zero_len (d_zero)
    );

    // Dispatch decisions for the word offered this cycle.
    always_comb begin
        ibuf_ready   = !busy;
        accept       = ibuf_valid && ibuf_ready;
        illegal      = accept && (d_cls == CLS_ILLEGAL);
        arm_rep      = accept && (d_cls == CLS_PREFIX);
        take_rep     = accept && (d_cls != CLS_PREFIX);
        start_run    = accept && ((d_cls == CLS_SINGLE) ||
                                  ((d_cls == CLS_ROWS) && !d_zero));
        quick_retire = accept && (d_cls == CLS_ROWS) && d_zero;
    end

    seq_repeat #(.LEN_W(LEN_W)) u_repeat (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (arm_rep),
        .arm_count    (d_len),
        .take         (take_rep),
        .extra_passes (extra_passes)
    );

    seq_loop #(
        .IN_AW(IN_AW), .OUT_AW(OUT_AW), .LEN_W(LEN_W), .FLAG_W(FLAG_W)
    ) u_loop (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start_run),
        .start_kind   (d_kind),
        .start_single (d_cls == CLS_SINGLE),
        .in_base      (d_in),
        .out_base     (d_out),
        .length       (d_len),
        .flags        (d_flags),
        .passes       (extra_passes),
        .uop_ready    (uop_ready),
        .busy         (busy),
        .kind         (loop_kind),
        .in_ptr       (uop_in_addr),
        .out_ptr      (uop_out_addr),
        .flags_q      (uop_flags),
        .pass_last    (uop_last),
        .done         (loop_done)
    );

    // Completion and error pulses, one cycle after the deciding event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retire_q      <= 1'b0;
            retire_kind_q <= KIND_NONE;
            err_q         <= 1'b0;
        end else begin
            retire_q      <= loop_done || quick_retire || illegal;
            retire_kind_q <= loop_done ? loop_kind :
                             (quick_retire ? d_kind : KIND_NONE);
            err_q         <= illegal;
        end
    end

    // Drive the remaining outputs.
    always_comb begin
        uop_valid   = busy;
        uop_kind    = busy ? loop_kind : KIND_NONE;
        retire      = retire_q;
        retire_kind = retire_kind_q;
        err         = err_q;
    end
endmodule

// File: rtl/seq_checks.sv
// Protocol checks for the sequencer ports, attached to the top by bind.
module seq_checks
    import seq_pkg::*;
#(
    parameter int IN_AW  = 24,
    parameter int OUT_AW = 16,
    parameter int FLAG_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ibuf_ready,
    input logic              uop_valid,
    input logic              uop_ready,
    input logic [2:0]        uop_kind,
    input logic [IN_AW-1:0]  uop_in_addr,
    input logic [OUT_AW-1:0] uop_out_addr,
    input logic [FLAG_W-1:0] uop_flags,
    input logic              uop_last,
    input logic              retire,
    input logic [2:0]        retire_kind,
    input logic              err
);
    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_in_addr) &&
        $stable(uop_out_addr) && $stable(uop_kind) && $stable(uop_flags));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && uop_ready && !uop_last |=> uop_valid &&
        (uop_in_addr == IN_AW'($past(uop_in_addr) + 1'b1)) &&
        (uop_out_addr == OUT_AW'($past(uop_out_addr) + 1'b1)));

    assert_no_fetch_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !ibuf_ready);

    assert_weights_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid && (uop_kind == 3'(KIND_WEIGHTS)) |-> uop_last);

    assert_err_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> retire && (retire_kind == 3'(KIND_NONE)) && !uop_valid);
endmodule

bind accel_instr_seq seq_checks #(
    .IN_AW(IN_AW), .OUT_AW(OUT_AW), .FLAG_W(FLAG_W)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .ibuf_ready   (ibuf_ready),
    .uop_valid    (uop_valid),
    .uop_ready    (uop_ready),
    .uop_kind     (uop_kind),
    .uop_in_addr  (uop_in_addr),
    .uop_out_addr (uop_out_addr),
    .uop_flags    (uop_flags),
    .uop_last     (uop_last),
    .retire       (retire),
    .retire_kind  (retire_kind),
    .err          (err)
);

// File: tb/accel_instr_seq_test.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, zero length, the repeat prefix and illegal opcodes.
module accel_instr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ibuf_valid = 1'b0;
    logic [95:0] ibuf_data = '0;
    logic        ibuf_ready;
    logic        uop_valid;
    logic        uop_ready = 1'b1;
    logic [2:0]  uop_kind;
    logic [23:0] uop_in_addr;
    logic [15:0] uop_out_addr;
    logic [15:0] uop_flags;
    logic        uop_last;
    logic        retire;
    logic [2:0]  retire_kind;
    logic        err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    accel_instr_seq uut (
        .clk(clk), .rst_n(rst_n), .ibuf_valid(ibuf_valid), .ibuf_data(ibuf_data),
        .ibuf_ready(ibuf_ready), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_kind(uop_kind), .uop_in_addr(uop_in_addr), .uop_out_addr(uop_out_addr),
        .uop_flags(uop_flags), .uop_last(uop_last), .retire(retire),
        .retire_kind(retire_kind), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [7:0]  opc;
        logic [23:0] in_a;
        logic [15:0] out_a;
        logic [31:0] len;
        logic [15:0] flg;
        logic [2:0]  kind;
        logic        stall;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'h30, 24'h000100, 16'h0040, 32'd5, 16'h0001, 3'd4, 1'b0},
        '{8'h11, 24'h0A0000, 16'h1234, 32'd3, 16'h0000, 3'd1, 1'b1},
        '{8'h12, 24'h000010, 16'h0000, 32'd2, 16'h8000, 3'd2, 1'b0},
        '{8'h40, 24'h000200, 16'h0300, 32'd4, 16'h0002, 3'd5, 1'b1},
        '{8'h20, 24'h00ABCD, 16'h0001, 32'd7, 16'h0000, 3'd3, 1'b1},
        '{8'h30, 24'hFFFFFE, 16'hFFFF, 32'd3, 16'h0004, 3'd4, 1'b1}
    };

    function automatic logic [95:0] mk(input logic [7:0] opc, input logic [15:0] flg,
                                       input logic [31:0] len, input logic [15:0] out_a,
                                       input logic [23:0] in_a);
        return {opc, flg, len, out_a, in_a};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h, expected %0h", req, act, exp);
        end
    endtask

    // Offer a word until accepted, then drop valid at the next falling edge.
    task automatic send(input logic [95:0] w);
        @(negedge clk);
        ibuf_valid = 1'b1;
        ibuf_data  = w;
        while (!ibuf_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        ibuf_valid = 1'b0;
    endtask

    // Follow one instruction to its retire pulse, checking every row.
    task automatic collect(input logic [2:0] ekind, input logic [23:0] ein,
                           input logic [15:0] eout, input logic [15:0] eflg,
                           input int plen, input int total, input bit stall,
                           input bit eerr, input string req);
        int rows = 0;
        int cyc = 0;
        bit seen = 0;
        bit held = 0;
        logic [23:0] h_in;
        logic [15:0] h_out;
        while (!seen && cyc < 500) begin
            uop_ready = stall ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (held) begin
                check(uop_valid && uop_in_addr == h_in && uop_out_addr == h_out,
                      "R4 hold under stall", longint'(uop_in_addr), longint'(h_in));
            end
            held = 0;
            if (uop_valid) begin
                if (uop_ready) begin
                    int idx = (plen > 0) ? rows % plen : 0;
                    logic [23:0] xi = ein + 24'(idx);
                    logic [15:0] xo = eout + 16'(idx);
                    check(uop_in_addr == xi, {req, " R3 in addr"}, longint'(uop_in_addr), longint'(xi));
                    check(uop_out_addr == xo, {req, " R3 out addr"}, longint'(uop_out_addr), longint'(xo));
                    check(uop_last == (idx == plen - 1), {req, " R3 last"}, longint'(uop_last),
                          longint'(idx == plen - 1));
                    check(uop_kind == ekind, {req, " R10 uop kind"}, longint'(uop_kind), longint'(ekind));
                    check(uop_flags == eflg, {req, " R2 flags"}, longint'(uop_flags), longint'(eflg));
                    rows++;
                end else begin
                    held = 1;
                    h_in = uop_in_addr;
                    h_out = uop_out_addr;
                end
            end
            if (retire) begin
                seen = 1;
                check(retire_kind == ekind, {req, " R5 retire kind"}, longint'(retire_kind), longint'(ekind));
                check(err == eerr, {req, " R9 err"}, longint'(err), longint'(eerr));
                check(ibuf_ready == 1'b1, {req, " R5 ready at retire"}, longint'(ibuf_ready), 1);
            end
            cyc++;
            if (!seen) @(negedge clk);
        end
        check(seen, {req, " R5 retire seen"}, longint'(seen), 1);
        check(rows == total, {req, " row count"}, longint'(rows), longint'(total));
        // Retire must last one cycle only.
        @(negedge clk);
        #1;
        check(!retire, {req, " R5 single pulse"}, longint'(retire), 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!uop_valid && !retire && !err && ibuf_ready, "R1 in reset",
              longint'({uop_valid, retire, err, ibuf_ready}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!uop_valid && !retire && !err && ibuf_ready, "R1 after release",
              longint'({uop_valid, retire, err, ibuf_ready}), 1);

        // Table walk: R2, R3, R4, R5, R6, R10
        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VECS[i];
            int plen = (v.opc == 8'h20) ? 1 : int'(v.len);
            send(mk(v.opc, v.flg, v.len, v.out_a, v.in_a));
            collect(v.kind, v.in_a, v.out_a, v.flg, plen, plen, v.stall, 1'b0,
                    (v.opc == 8'h20) ? "R6 weights" : "R3 rows");
        end

        // R7: zero-length row instruction
        send(mk(8'h30, 16'h0, 32'd0, 16'h0010, 24'h000020));
        collect(3'd4, 24'h000020, 16'h0010, 16'h0, 1, 0, 1'b0, 1'b0, "R7 zero length");

        // R8: repeat prefix with count 2 on a three-row multiply
        send(mk(8'hF0, 16'h0, 32'd2, 16'h0, 24'h0));
        #1;
        check(!uop_valid && !retire, "R8 prefix idle", longint'({uop_valid, retire}), 0);
        send(mk(8'h30, 16'h0003, 32'd3, 16'h0500, 24'h000700));
        collect(3'd4, 24'h000700, 16'h0500, 16'h0003, 3, 9, 1'b1, 1'b0, "R8 repeat");

        // R8: the count is consumed; the next instruction runs once
        send(mk(8'h40, 16'h0, 32'd2, 16'h0020, 24'h000030));
        collect(3'd5, 24'h000030, 16'h0020, 16'h0, 2, 2, 1'b0, 1'b0, "R8 consumed");

        // R9: illegal opcode after a prefix; prefix discarded
        send(mk(8'hF0, 16'h0, 32'd3, 16'h0, 24'h0));
        send(mk(8'h77, 16'h0, 32'd4, 16'h0, 24'h0));
        collect(3'd0, 24'h0, 16'h0, 16'h0, 1, 0, 1'b0, 1'b1, "R9 illegal");
        send(mk(8'h12, 16'h0, 32'd2, 16'h0100, 24'h000200));
        collect(3'd2, 24'h000200, 16'h0100, 16'h0, 2, 2, 1'b0, 1'b0, "R9 repeat discarded");

        // R6: weights with repeat count 1 -> two single-row passes
        send(mk(8'hF0, 16'h0, 32'd1, 16'h0, 24'h0));
        send(mk(8'h20, 16'h0, 32'd0, 16'h0000, 24'h001234));
        collect(3'd3, 24'h001234, 16'h0000, 16'h0, 1, 2, 1'b0, 1'b0, "R6 weights repeated");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule